// File: doc/BRIEF.md
# Serial Host Port for a Segment Display Controller

This block is the host-facing front end of a memory-mapped segment display controller. A host talks to it over a frame select, a write strobe, a read strobe and one data line. The data line is split here into an input, an output and an output enable for the pad. Each frame opens with a three-bit mode code. The code selects a nibble read, a nibble write, a read-then-write of each nibble, or a command stream. Strobes and the data line are oversampled on the system clock through a synchronizer, so every protocol action is taken in the system clock domain.

In the data modes a six-bit address follows the mode code. Four-bit nibbles then stream to or from a 32-entry nibble store, and the address steps by one after every nibble. In command mode the block collects nine-bit words and presents each one with a one-cycle valid pulse to a configuration decoder downstream. The display driver reads the same nibble store through a separate asynchronous read port.

Top module: `lcd_serial_slave`

## Requirements
- R1: After reset the data output enable is low, no command pulse is given, and every nibble of the store reads 0 on the display port.
- R2: The first three bits of a frame, most significant first, are a mode code: 110 selects read, 101 selects write (or read-then-write), 100 selects command mode. Any other code makes the rest of the frame have no effect.
- R3: In a 101 frame the address follows as A5 down to A0, then the nibble as D0 first to D3 last, each bit taken at a rising write strobe. The store index is A4..A0; A5 has no effect.
- R4: In a 110 frame each falling read strobe drives the next nibble bit, D0 first, onto the data output. The output enable rises at the first falling read strobe and stays high until the frame ends.
- R5: While select stays low, each completed nibble moves the access to the next index, wrapping from 31 to 0, in read, write and read-then-write.
- R6: In a 101 frame a falling read strobe at a nibble boundary starts a read-then-write step. Four read strobes return the stored nibble. The output enable falls at the read strobe rise after the fourth bit. Four write strobes then store a new nibble at the same index before the index steps.
- R7: In a 100 frame each group of nine bits, C8 first, produces one command word with a valid pulse one clock cycle long. Further words follow back to back without a new mode code.
- R8: A high level on select ends the frame. A partial nibble is not stored, a partial command word is not issued, the output enable falls, and the next frame must begin with a mode code.
- R9: The display port returns the stored nibble at the given index combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| host_sel_n_i | input | 1 | Frame select from the host, low active |
| host_wr_i | input | 1 | Write strobe; bit taken on its rising edge |
| host_rd_i | input | 1 | Read strobe; bit driven from its falling edge |
| host_dat_i | input | 1 | Data line as seen at the pad input |
| host_dat_o | output | 1 | Data line value to drive during reads |
| host_dat_oe_o | output | 1 | Pad output enable for the data line |
| cmd_valid_o | output | 1 | One-cycle pulse for a complete command word |
| cmd_word_o | output | CMD_W | Command word, first received bit in the MSB |
| disp_idx_i | input | IDX_W | Display driver read index |
| disp_nib_o | output | NIB_W | Stored nibble at disp_idx_i |

## Verification
A wrong bit or frame counter shows at the ports within one nibble. The display port then holds a nibble at a shifted index or with rotated bits, or a command word arrives with rotated bits or with no pulse. These show a few strobe periods after the faulty frame ends. Stale mode state after select rises, or a wrong write/read-then-write decision, shows in the next frame: the store changes where it should not, or the output enable is high during a write. A fault in index stepping or wrapping appears on the first multi-nibble burst that crosses index 31.

// File: rtl/lss_pkg.sv
package lss_pkg;

    localparam int LSS_ID_W = 3;

    localparam logic [LSS_ID_W-1:0] CODE_READ  = 3'b110;
    localparam logic [LSS_ID_W-1:0] CODE_WRITE = 3'b101;
    localparam logic [LSS_ID_W-1:0] CODE_CMD   = 3'b100;

    typedef enum logic [2:0] {
        ST_CODE,
        ST_ADDR,
        ST_NIB,
        ST_CMD,
        ST_DEAD
    } lss_state_e;

    typedef enum logic [1:0] {
        MD_NONE,
        MD_READ,
        MD_WRITE,
        MD_CMD
    } lss_mode_e;

    // synchronized host events, one system clock cycle each
    typedef struct packed {
        logic sel_hi;
        logic wr_rise;
        logic rd_fall;
        logic rd_rise;
        logic din;
    } lss_evt_t;

    function automatic lss_mode_e decode_code(input logic [LSS_ID_W-1:0] code);
        case (code)
            CODE_READ:  return MD_READ;
            CODE_WRITE: return MD_WRITE;
            CODE_CMD:   return MD_CMD;
            default:    return MD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lss_sync_edge.sv
module lss_sync_edge #(
    parameter int              STAGES  = 2,
    parameter int              WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i)
                chain[g] <= RST_VAL;
            else if (g == 0)
                chain[g] <= async_i;
            else
                chain[g] <= chain[(g == 0) ? 0 : g-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= RST_VAL;
        else       prev_q <= chain[STAGES-1];
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~prev_q;
    assign fall_o  = ~chain[STAGES-1] & prev_q;
endmodule

// File: rtl/lss_nibble_ram.sv
module lss_nibble_ram #(
    parameter int IDX_W = 5,
    parameter int NIB_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [NIB_W-1:0] wdata_i,
    input  logic [IDX_W-1:0] ridx_a_i,
    output logic [NIB_W-1:0] rdata_a_o,
    input  logic [IDX_W-1:0] ridx_b_i,
    output logic [NIB_W-1:0] rdata_b_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [NIB_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk_i) begin
            if (rst_i)
                cells[i] <= '0;
            else if (we_i && widx_i == IDX_W'(i))
                cells[i] <= wdata_i;
        end
    end

    assign rdata_a_o = cells[ridx_a_i];
    assign rdata_b_o = cells[ridx_b_i];
endmodule

// File: rtl/lss_frame_ctrl.sv
module lss_frame_ctrl
    import lss_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 5,
    parameter int NIB_W  = 4,
    parameter int CMD_W  = 9
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  lss_evt_t         evt_i,
    output logic             ram_we_o,
    output logic [IDX_W-1:0] ram_idx_o,
    output logic [NIB_W-1:0] ram_wdata_o,
    input  logic [NIB_W-1:0] ram_rdata_i,
    output logic             dat_o,
    output logic             dat_oe_o,
    output logic             cmd_valid_o,
    output logic [CMD_W-1:0] cmd_word_o,
    output logic             in_cmd_o,
    output logic             wr_mode_o
);
    localparam int MAXB  = (CMD_W > ADDR_W) ? CMD_W : ADDR_W;
    localparam int CNT_W = $clog2(MAXB + 1);
    localparam int RB_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1;

    lss_state_e       state_q;
    lss_mode_e        mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CMD_W-1:0] shreg_q;
    logic [CMD_W-1:0] shreg_nx;
    logic [IDX_W-1:0] idx_q;
    logic [NIB_W-1:0] nib_q;
    logic [RB_W-1:0]  rbit_q;
    logic             rmw_done_q;
    logic             dout_q;
    logic             oe_q;
    logic             cmd_vld_q;
    logic [CMD_W-1:0] cmd_q;
    logic             wr_accept;

    assign shreg_nx  = {shreg_q[CMD_W-2:0], evt_i.din};
    assign wr_accept = (state_q == ST_NIB) && (mode_q == MD_WRITE) &&
                       evt_i.wr_rise && (rbit_q == '0);

    assign ram_we_o = wr_accept && (cnt_q == CNT_W'(NIB_W-1));

    always_comb begin
        ram_wdata_o           = nib_q;
        ram_wdata_o[NIB_W-1]  = evt_i.din;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || evt_i.sel_hi) begin
            state_q    <= ST_CODE;
            mode_q     <= MD_NONE;
            cnt_q      <= '0;
            shreg_q    <= '0;
            idx_q      <= '0;
            nib_q      <= '0;
            rbit_q     <= '0;
            rmw_done_q <= 1'b0;
            dout_q     <= 1'b0;
            oe_q       <= 1'b0;
            cmd_vld_q  <= 1'b0;
            cmd_q      <= rst_i ? '0 : cmd_q;
        end else begin
            cmd_vld_q <= 1'b0;
            case (state_q)
                ST_CODE: if (evt_i.wr_rise) begin
                    shreg_q <= shreg_nx;
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(LSS_ID_W-1)) begin
                        cnt_q  <= '0;
                        mode_q <= decode_code(shreg_nx[LSS_ID_W-1:0]);
                        case (decode_code(shreg_nx[LSS_ID_W-1:0]))
                            MD_CMD:  state_q <= ST_CMD;
                            MD_NONE: state_q <= ST_DEAD;
                            default: state_q <= ST_ADDR;
                        endcase
                    end
                end
                ST_ADDR: if (evt_i.wr_rise) begin
                    shreg_q <= shreg_nx;
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(ADDR_W-1)) begin
                        cnt_q   <= '0;
                        idx_q   <= shreg_nx[IDX_W-1:0];
                        state_q <= ST_NIB;
                    end
                end
                ST_NIB: begin
                    if (mode_q == MD_READ) begin
                        if (evt_i.rd_fall) begin
                            dout_q <= ram_rdata_i[rbit_q];
                            oe_q   <= 1'b1;
                            rbit_q <= rbit_q + 1'b1;
                            if (rbit_q == RB_W'(NIB_W-1)) begin
                                rbit_q <= '0;
                                idx_q  <= idx_q + 1'b1;
                            end
                        end
                    end else begin
                        if (wr_accept) begin
                            nib_q[cnt_q[RB_W-1:0]] <= evt_i.din;
                            cnt_q <= cnt_q + 1'b1;
                            if (cnt_q == CNT_W'(NIB_W-1)) begin
                                cnt_q      <= '0;
                                idx_q      <= idx_q + 1'b1;
                                rmw_done_q <= 1'b0;
                            end
                        end else if (evt_i.rd_fall && cnt_q == '0 && !rmw_done_q) begin
                            dout_q <= ram_rdata_i[rbit_q];
                            oe_q   <= 1'b1;
                            rbit_q <= rbit_q + 1'b1;
                            if (rbit_q == RB_W'(NIB_W-1)) begin
                                rbit_q     <= '0;
                                rmw_done_q <= 1'b1;
                            end
                        end else if (evt_i.rd_rise && rmw_done_q) begin
                            oe_q <= 1'b0;
                        end
                    end
                end
                ST_CMD: if (evt_i.wr_rise) begin
                    shreg_q <= shreg_nx;
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(CMD_W-1)) begin
                        cnt_q     <= '0;
                        cmd_vld_q <= 1'b1;
                        cmd_q     <= shreg_nx;
                    end
                end
                default: ;
            endcase
        end
    end

    assign ram_idx_o   = idx_q;
    assign dat_o       = dout_q;
    assign dat_oe_o    = oe_q;
    assign cmd_valid_o = cmd_vld_q;
    assign cmd_word_o  = cmd_q;
    assign in_cmd_o    = (state_q == ST_CMD);
    assign wr_mode_o   = (state_q == ST_NIB) && (mode_q == MD_WRITE);
endmodule

// File: rtl/lcd_serial_slave.sv
module lcd_serial_slave
    import lss_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int IDX_W       = 5,
    parameter int NIB_W       = 4,
    parameter int CMD_W       = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             host_sel_n_i,
    input  logic             host_wr_i,
    input  logic             host_rd_i,
    input  logic             host_dat_i,
    output logic             host_dat_o,
    output logic             host_dat_oe_o,
    output logic             cmd_valid_o,
    output logic [CMD_W-1:0] cmd_word_o,
    input  logic [IDX_W-1:0] disp_idx_i,
    output logic [NIB_W-1:0] disp_nib_o
);
    localparam int PIN_SEL = 0;
    localparam int PIN_WR  = 1;
    localparam int PIN_RD  = 2;
    localparam int PIN_DAT = 3;
    localparam int PINS    = 4;

    logic [PINS-1:0]  pin_lvl, pin_rise, pin_fall;
    lss_evt_t         evt;
    logic             ram_we;
    logic [IDX_W-1:0] ram_idx;
    logic [NIB_W-1:0] ram_wdata, ram_rdata;
    logic             in_cmd, wr_mode;

    lss_sync_edge #(.STAGES(SYNC_STAGES), .WIDTH(PINS), .RST_VAL('1)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i ({host_dat_i, host_rd_i, host_wr_i, host_sel_n_i}),
        .level_o (pin_lvl),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    assign evt.sel_hi  = pin_lvl[PIN_SEL];
    assign evt.wr_rise = pin_rise[PIN_WR];
    assign evt.rd_fall = pin_fall[PIN_RD];
    assign evt.rd_rise = pin_rise[PIN_RD];
    assign evt.din     = pin_lvl[PIN_DAT];

    lss_frame_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NIB_W(NIB_W), .CMD_W(CMD_W)) u_ctrl (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .evt_i       (evt),
        .ram_we_o    (ram_we),
        .ram_idx_o   (ram_idx),
        .ram_wdata_o (ram_wdata),
        .ram_rdata_i (ram_rdata),
        .dat_o       (host_dat_o),
        .dat_oe_o    (host_dat_oe_o),
        .cmd_valid_o (cmd_valid_o),
        .cmd_word_o  (cmd_word_o),
        .in_cmd_o    (in_cmd),
        .wr_mode_o   (wr_mode)
    );

    lss_nibble_ram #(.IDX_W(IDX_W), .NIB_W(NIB_W)) u_ram (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .we_i      (ram_we),
        .widx_i    (ram_idx),
        .wdata_i   (ram_wdata),
        .ridx_a_i  (ram_idx),
        .rdata_a_o (ram_rdata),
        .ridx_b_i  (disp_idx_i),
        .rdata_b_o (disp_nib_o)
    );
endmodule

// File: rtl/lss_checker.sv
module lss_checker #(
    parameter int IDX_W = 5
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             sel_hi,
    input logic             rd_fall,
    input logic             dat_oe,
    input logic             cmd_valid,
    input logic             in_cmd,
    input logic             ram_we,
    input logic             wr_mode,
    input logic [IDX_W-1:0] ram_idx
);
    assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!dat_oe && !cmd_valid));

    assert_oe_starts_on_read_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(dat_oe) |-> $past(rd_fall));

    assert_select_releases_oe_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        sel_hi |=> !dat_oe);

    assert_cmd_single_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_valid |=> !cmd_valid);

    assert_cmd_only_in_cmd_mode_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_valid |-> $past(in_cmd));

    assert_store_only_in_write_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        ram_we |-> wr_mode);

    assert_index_steps_after_store_R5: assert property (@(posedge clk_i) disable iff (rst_i || sel_hi)
        ram_we |=> (ram_idx == $past(ram_idx) + IDX_W'(1)));
endmodule

bind lcd_serial_slave lss_checker #(.IDX_W(IDX_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sel_hi    (evt.sel_hi),
    .rd_fall   (evt.rd_fall),
    .dat_oe    (host_dat_oe_o),
    .cmd_valid (cmd_valid_o),
    .in_cmd    (in_cmd),
    .ram_we    (ram_we),
    .wr_mode   (wr_mode),
    .ram_idx   (ram_idx)
);

// File: tb/lcd_serial_slave_tb.sv
module lcd_serial_slave_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1, wr = 1'b1, rd = 1'b1, din = 1'b1;
    logic       dout, doe, cvld;
    logic [8:0] cword;
    logic [4:0] didx = '0;
    logic [3:0] dnib;

    int checks = 0;
    int errors = 0;

    logic [8:0] exp_cmd[$];
    logic [3:0] exp_rd[$];
    logic [3:0] model [32];

    always #2.5 clk = ~clk;

    lcd_serial_slave u_dut (
        .clk_i(clk), .rst_i(rst), .host_sel_n_i(sel_n), .host_wr_i(wr),
        .host_rd_i(rd), .host_dat_i(din), .host_dat_o(dout),
        .host_dat_oe_o(doe), .cmd_valid_o(cvld), .cmd_word_o(cword),
        .disp_idx_i(didx), .disp_nib_o(dnib)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: command words against the scoreboard (R7, R8)
    always @(negedge clk) begin
        if (!rst && cvld) begin
            if (exp_cmd.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7/R8 unexpected command actual=%0h expected=none", cword);
            end else begin
                chk("R7 command word", 16'(cword), 16'(exp_cmd.pop_front()));
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_begin();
        sel_n = 1'b0; wait_n(4);
    endtask

    task automatic frame_end();
        sel_n = 1'b1; wr = 1'b1; rd = 1'b1; wait_n(6);
    endtask

    task automatic wbit(input logic b);
        din = b; wr = 1'b0; wait_n(4);
        wr = 1'b1; wait_n(4);
    endtask

    task automatic send_code(input logic [2:0] c);
        for (int k = 2; k >= 0; k--) wbit(c[k]);
    endtask

    task automatic send_addr(input logic [5:0] a);
        for (int k = 5; k >= 0; k--) wbit(a[k]);
    endtask

    task automatic send_nib(input logic [3:0] v);
        for (int k = 0; k < 4; k++) wbit(v[k]);
    endtask

    task automatic send_cmd(input logic [8:0] w);
        exp_cmd.push_back(w);
        for (int k = 8; k >= 0; k--) wbit(w[k]);
    endtask

    task automatic read_nib(output logic [3:0] v);
        for (int k = 0; k < 4; k++) begin
            rd = 1'b0; wait_n(6);
            v[k] = dout;
            rd = 1'b1; wait_n(4);
        end
    endtask

    task automatic read_and_score(input string tag);
        logic [3:0] got;
        read_nib(got);
        chk(tag, 16'(got), 16'(exp_rd.pop_front()));
    endtask

    task automatic disp_check(input string tag, input int idx);
        didx = 5'(idx); wait_n(1);
        chk(tag, 16'(dnib), 16'(model[idx]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        wait_n(5);
        rst = 1'b0;
        wait_n(2);

        // R1: reset state
        chk("R1 oe after reset", 16'(doe), 16'h0);
        chk("R1 no command after reset", 16'(cvld), 16'h0);
        disp_check("R1 store cleared", 5);
        disp_check("R1 store cleared", 31);

        // R3/R9: single write at index 5
        frame_begin(); send_code(3'b101); send_addr(6'd5); send_nib(4'h9);
        chk("R4 oe low during write", 16'(doe), 16'h0);
        frame_end(); model[5] = 4'h9;
        disp_check("R3 R9 write idx5", 5);

        // R5: burst write wrapping 30,31,0
        frame_begin(); send_code(3'b101); send_addr(6'd30);
        send_nib(4'hA); send_nib(4'hB); send_nib(4'hC); frame_end();
        model[30] = 4'hA; model[31] = 4'hB; model[0] = 4'hC;
        disp_check("R5 burst idx30", 30);
        disp_check("R5 burst idx31", 31);
        disp_check("R5 wrap idx0", 0);

        // R3: A5 has no effect on index
        frame_begin(); send_code(3'b101); send_addr(6'h23); send_nib(4'h7); frame_end();
        model[3] = 4'h7;
        disp_check("R3 A5 ignored idx3", 3);

        // R4/R5: burst read wrapping, D0 first
        frame_begin(); send_code(3'b110); send_addr(6'd30);
        exp_rd.push_back(model[30]); exp_rd.push_back(model[31]); exp_rd.push_back(model[0]);
        read_and_score("R4 read idx30");
        chk("R4 oe held in read", 16'(doe), 16'h1);
        read_and_score("R5 read idx31");
        read_and_score("R5 read wrap idx0");
        frame_end();
        chk("R8 oe released at select high", 16'(doe), 16'h0);

        // R6: read-then-write at 5 and 6
        frame_begin(); send_code(3'b101); send_addr(6'd5);
        exp_rd.push_back(model[5]);
        read_and_score("R6 rmw read idx5");
        chk("R6 oe dropped after read half", 16'(doe), 16'h0);
        send_nib(4'h4);
        exp_rd.push_back(model[6]);
        read_and_score("R6 rmw read idx6");
        send_nib(4'h6);
        frame_end();
        model[5] = 4'h4; model[6] = 4'h6;
        disp_check("R6 rmw stored idx5", 5);
        disp_check("R6 rmw stored idx6", 6);

        // R7: back-to-back commands
        frame_begin(); send_code(3'b100);
        send_cmd(9'h1A5); send_cmd(9'h003); send_cmd(9'h155);
        frame_end();
        chk("R7 all commands seen", 16'(exp_cmd.size()), 16'h0);

        // R8: aborted nibble, aborted command
        frame_begin(); send_code(3'b101); send_addr(6'd8); wbit(1'b1); wbit(1'b1); frame_end();
        disp_check("R8 partial nibble not stored", 8);
        frame_begin(); send_code(3'b100); for (int k = 0; k < 5; k++) wbit(1'b1); frame_end();
        chk("R8 no partial command", 16'(exp_cmd.size()), 16'h0);
        // next frame needs a fresh code: 101 then addr 8
        frame_begin(); send_code(3'b101); send_addr(6'd8); send_nib(4'hE); frame_end();
        model[8] = 4'hE;
        disp_check("R8 new frame after abort", 8);

        // R2: unknown code leaves the store and commands alone
        frame_begin(); send_code(3'b111); send_addr(6'd9); send_nib(4'hF);
        for (int k = 0; k < 9; k++) wbit(1'b1);
        chk("R2 oe stays low", 16'(doe), 16'h0);
        frame_end();
        disp_check("R2 unknown code no store", 9);
        frame_begin(); send_code(3'b011); send_addr(6'd3); send_nib(4'h0); frame_end();
        disp_check("R2 unknown code idx3 kept", 3);
        chk("R2 no command", 16'(exp_cmd.size()), 16'h0);

        wait_n(10);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule